// File: doc/BRIEF.md
# I2C Host Interrupt Flag Controller

This block keeps the eight-bit interrupt flag register of an I2C host controller. Five flags are live: an error summary, a receive-FIFO-at-threshold flag, a transmit-FIFO-space flag, a client-byte-received flag and a host-byte-done flag. Each flag is set by its own hardware event and cleared by its own hardware condition. Software also clears any flag by writing a one to it over a simple register bus.

The two byte-done flags also raise a clock-stretch request, which tells the bit engine to hold SCL low. That request is kept in its own register, apart from the flag bits. Clearing a flag by writing one to it does not let the transfer continue. Only a release access does that: a write to the address register, a write to the data register, a smart-mode read of the data register, or a write of a nonzero command. The interrupt line is the registered OR of the flags masked by an enable input.

Top module: `i2c_hflag_ctrl`

## Requirements
- R1: Reset is synchronous and active high. During and after reset the flag register reads 0x00, and `scl_hold` and `irq` are low. Bits 2, 5 and 6 of the flag register always read zero.
- R2: A bus write to the flag offset (0x18) clears every live flag whose write-data bit is one. Bits written as zero are unchanged.
- R3: The error flag (bit 7) sets in the cycle after any bit of `err_src` is high, or `ev_arb_lost`, `ev_nack_arb_lost` or `ev_bus_err` is high. No hardware condition clears it.
- R4: The receive flag (bit 4) sets when `rx_level` changes from failing to meeting the condition (level nonzero and level >= `rx_thresh`). It does not set again while the condition stays true. It clears when `rx_level` is zero.
- R5: The transmit flag (bit 3) sets when the free count (DEPTH - `tx_level`) changes from failing to meeting the condition (free nonzero and free >= `tx_thresh`). It clears when the FIFO is full (free count zero).
- R6: The client flag (bit 1) sets on `ev_rx_done` unless `ev_arb_lost` or `ev_bus_err` is high in the same cycle. Whenever it sets, `scl_hold` is high in the next cycle.
- R7: The host flag (bit 0) sets on `ev_tx_done` whatever errors occur with it, on `ev_nack_arb_lost`, and on `ev_start_unknown`. `scl_hold` rises with it only if neither `ev_arb_lost` nor `ev_nack_arb_lost` is high in that cycle.
- R8: A release access clears bits 1 and 0 and `scl_hold`. The release accesses are: a write to offset 0x24, a write to 0x28, a read of 0x28 while `smart_en` is high, or a write to 0x04 with write-data bits [1:0] nonzero. A data read with `smart_en` low, or a command write with bits [1:0] zero, changes nothing.
- R9: Clearing bits 1 and 0 through the flag offset leaves `scl_hold` asserted.
- R10: When a set event and a clear arrive in the same cycle, the flag ends set. The clear may be a write-one, a release or a hardware clear. A release in the same cycle as a hold-raising event leaves `scl_hold` high.
- R11: `irq` is high one cycle after any flag bit ANDed with `irq_en` is high, and low one cycle after none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_done | input | 1 | Byte transmitted in host write mode (pulse) |
| ev_rx_done | input | 1 | Byte received in host read mode (pulse) |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| ev_nack_arb_lost | input | 1 | Arbitration lost while sending NACK in read mode (pulse) |
| ev_bus_err | input | 1 | Bus error (pulse) |
| ev_start_unknown | input | 1 | Start issued with bus state unknown (pulse) |
| err_src | input | ERR_N | Other error status sources: length, two extended timeouts, low timeout |
| rx_level | input | LW | Receive FIFO fill level |
| rx_thresh | input | LW | Receive threshold |
| tx_level | input | LW | Transmit FIFO fill level |
| tx_thresh | input | LW | Transmit free-space threshold |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | 8 | Register write data |
| smart_en | input | 1 | Smart mode enable |
| irq_en | input | 8 | Interrupt enable mask |
| flags | output | 8 | Flag register |
| scl_hold | output | 1 | SCL stretch request |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench targets the set-versus-clear collisions. A design that let a clear win would lose an error event or a byte-done event in that cycle. It also targets the split between a flag and the stretch request. A design that tied `scl_hold` to the flag bit would release SCL on a write-one clear. A design that raised it on every host event would stretch after lost arbitration. It also probes the near-miss bus accesses: a data read with smart mode off, a zero command, and writes of zero to the flag offset. A loose decoder would release SCL or clear flags on these. Finally, the FIFO flags are held at their threshold across a write-one clear. A level-triggered design would set the flag again and never let software acknowledge it.

// File: rtl/i2c_hflag_pkg.sv
package i2c_hflag_pkg;

  localparam int FLAG_W    = 8;
  localparam int NUM_LIVE  = 5;

  // Live flag positions inside the register
  localparam int POS_MB    = 0;
  localparam int POS_SB    = 1;
  localparam int POS_TXFE  = 3;
  localparam int POS_RXFF  = 4;
  localparam int POS_ERR   = 7;

  // Per-flag event vector; packed index 0 = host flag ... 4 = error flag
  typedef struct packed {
    logic err;
    logic rxff;
    logic txfe;
    logic sb;
    logic mb;
  } flag_ev_t;

  function automatic int live_pos(input int idx);
    case (idx)
      0:       return POS_MB;
      1:       return POS_SB;
      2:       return POS_TXFE;
      3:       return POS_RXFF;
      default: return POS_ERR;
    endcase
  endfunction

endpackage

// File: rtl/i2c_hflag_decode.sv
module i2c_hflag_decode #(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] FLAG_OFS = 8'h18,
  parameter logic [AW-1:0] ADDR_OFS = 8'h24,
  parameter logic [AW-1:0] DATA_OFS = 8'h28,
  parameter logic [AW-1:0] CMD_OFS  = 8'h04,
  parameter int          CMD_LSB  = 0,
  parameter int          CMD_W    = 2
) (
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          smart_en,
  output logic [7:0]    w1c_o,
  output logic          release_o
);

  logic hit_flag, hit_addr, hit_data, hit_cmd, cmd_nonzero;

  always_comb begin
    hit_flag    = (bus_addr == FLAG_OFS);
    hit_addr    = (bus_addr == ADDR_OFS);
    hit_data    = (bus_addr == DATA_OFS);
    hit_cmd     = (bus_addr == CMD_OFS);
    cmd_nonzero = |bus_wdata[CMD_LSB +: CMD_W];
    w1c_o       = (bus_wr && hit_flag) ? bus_wdata : 8'h00;
    release_o   = (bus_wr && (hit_addr || hit_data))
                | (bus_rd && hit_data && smart_en)
                | (bus_wr && hit_cmd && cmd_nonzero);
  end

endmodule

// File: rtl/i2c_hflag_lvl.sv
module i2c_hflag_lvl #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter bit IS_TX = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] thresh_i,
  output logic          set_o,
  output logic          clr_o
);

  logic [LW-1:0] avail;
  logic          meet, meet_q;

  generate
    if (IS_TX) begin : g_free
      always_comb avail = LW'(DEPTH) - level_i;
    end else begin : g_fill
      always_comb avail = level_i;
    end
  endgenerate

  always_comb begin
    meet  = (avail != '0) && (avail >= thresh_i);
    set_o = meet && !meet_q;
    clr_o = (avail == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) meet_q <= 1'b0;
    else     meet_q <= meet;
  end

endmodule

// File: rtl/i2c_hflag_bit.sv
module i2c_hflag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= set_i | (q_o & ~clr_i);
  end

endmodule

// File: rtl/i2c_hflag_hold.sv
module i2c_hflag_hold (
  input  logic clk,
  input  logic rst,
  input  logic sb_set_i,
  input  logic mb_set_i,
  input  logic arb_any_i,
  input  logic release_i,
  output logic hold_o
);

  logic raise;

  always_comb raise = sb_set_i | (mb_set_i & ~arb_any_i);

  always_ff @(posedge clk) begin
    if (rst) hold_o <= 1'b0;
    else     hold_o <= raise | (hold_o & ~release_i);
  end

endmodule

// File: rtl/i2c_hflag_ctrl.sv
module i2c_hflag_ctrl
  import i2c_hflag_pkg::*;
#(
  parameter int            DEPTH    = 16,
  parameter int            LW       = $clog2(DEPTH + 1),
  parameter int            ERR_N    = 4,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] FLAG_OFS = 8'h18,
  parameter logic [AW-1:0] ADDR_OFS = 8'h24,
  parameter logic [AW-1:0] DATA_OFS = 8'h28,
  parameter logic [AW-1:0] CMD_OFS  = 8'h04,
  parameter int            CMD_LSB  = 0,
  parameter int            CMD_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  input  logic             ev_arb_lost,
  input  logic             ev_nack_arb_lost,
  input  logic             ev_bus_err,
  input  logic             ev_start_unknown,
  input  logic [ERR_N-1:0] err_src,
  input  logic [LW-1:0]    rx_level,
  input  logic [LW-1:0]    rx_thresh,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    tx_thresh,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             smart_en,
  input  logic [7:0]       irq_en,
  output logic [7:0]       flags,
  output logic             scl_hold,
  output logic             irq
);

  logic [7:0]          w1c;
  logic                rel;
  logic                rx_set, rx_clr, tx_set, tx_clr;
  logic                arb_any;
  flag_ev_t            hw_set, hw_clr;
  logic [NUM_LIVE-1:0] set_v, clr_v, bit_q;

  i2c_hflag_decode #(
    .AW(AW), .FLAG_OFS(FLAG_OFS), .ADDR_OFS(ADDR_OFS), .DATA_OFS(DATA_OFS),
    .CMD_OFS(CMD_OFS), .CMD_LSB(CMD_LSB), .CMD_W(CMD_W)
  ) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .smart_en(smart_en),
    .w1c_o(w1c), .release_o(rel)
  );

  i2c_hflag_lvl #(.DEPTH(DEPTH), .LW(LW), .IS_TX(1'b0)) u_rx (
    .clk(clk), .rst(rst), .level_i(rx_level), .thresh_i(rx_thresh),
    .set_o(rx_set), .clr_o(rx_clr)
  );

  i2c_hflag_lvl #(.DEPTH(DEPTH), .LW(LW), .IS_TX(1'b1)) u_tx (
    .clk(clk), .rst(rst), .level_i(tx_level), .thresh_i(tx_thresh),
    .set_o(tx_set), .clr_o(tx_clr)
  );

  always_comb begin
    arb_any      = ev_arb_lost | ev_nack_arb_lost;
    hw_set.err   = (|err_src) | arb_any | ev_bus_err;
    hw_set.rxff  = rx_set;
    hw_set.txfe  = tx_set;
    hw_set.sb    = ev_rx_done & ~ev_arb_lost & ~ev_bus_err;
    hw_set.mb    = ev_tx_done | ev_nack_arb_lost | ev_start_unknown;
    hw_clr.err   = 1'b0;
    hw_clr.rxff  = rx_clr;
    hw_clr.txfe  = tx_clr;
    hw_clr.sb    = rel;
    hw_clr.mb    = rel;
    set_v        = hw_set;
    clr_v        = hw_clr;
  end

  generate
    for (genvar i = 0; i < NUM_LIVE; i++) begin : g_flag
      i2c_hflag_bit u_bit (
        .clk(clk), .rst(rst),
        .set_i(set_v[i]),
        .clr_i(clr_v[i] | w1c[live_pos(i)]),
        .q_o(bit_q[i])
      );
    end
  endgenerate

  always_comb begin
    flags = 8'h00;
    for (int i = 0; i < NUM_LIVE; i++) flags[live_pos(i)] = bit_q[i];
  end

  i2c_hflag_hold u_hold (
    .clk(clk), .rst(rst),
    .sb_set_i(hw_set.sb), .mb_set_i(hw_set.mb),
    .arb_any_i(arb_any), .release_i(rel),
    .hold_o(scl_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & irq_en);
  end

endmodule

// File: rtl/i2c_hflag_ctrl_chk.sv
module i2c_hflag_ctrl_chk #(
  parameter int            LW       = 5,
  parameter int            ERR_N    = 4,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] FLAG_OFS = 8'h18,
  parameter logic [AW-1:0] ADDR_OFS = 8'h24,
  parameter logic [AW-1:0] DATA_OFS = 8'h28,
  parameter logic [AW-1:0] CMD_OFS  = 8'h04,
  parameter int            CMD_LSB  = 0,
  parameter int            CMD_W    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_tx_done,
  input logic             ev_rx_done,
  input logic             ev_arb_lost,
  input logic             ev_nack_arb_lost,
  input logic             ev_bus_err,
  input logic             ev_start_unknown,
  input logic [ERR_N-1:0] err_src,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             smart_en,
  input logic [7:0]       irq_en,
  input logic [7:0]       flags,
  input logic             scl_hold,
  input logic             irq
);

  logic chk_rel, chk_any_set;

  always_comb begin
    chk_rel = (bus_wr && (bus_addr == ADDR_OFS || bus_addr == DATA_OFS))
            || (bus_rd && bus_addr == DATA_OFS && smart_en)
            || (bus_wr && bus_addr == CMD_OFS && (|bus_wdata[CMD_LSB +: CMD_W]));
    chk_any_set = ev_rx_done || ev_tx_done || ev_nack_arb_lost || ev_start_unknown;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (flags == 8'h00 && !scl_hold && !irq));

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (flags[6:5] == 2'b00 && flags[2] == 1'b0));

  assert_error_set_R3: assert property (@(posedge clk) disable iff (rst)
    ((|err_src) || ev_arb_lost || ev_nack_arb_lost || ev_bus_err) |=> flags[7]);

  assert_sb_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_done && !ev_arb_lost && !ev_bus_err) |=> (flags[1] && scl_hold));

  assert_mb_set_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_done || ev_nack_arb_lost || ev_start_unknown) |=> flags[0]);

  assert_mb_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((ev_tx_done || ev_start_unknown) && !ev_arb_lost && !ev_nack_arb_lost) |=> scl_hold);

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_rel && !chk_any_set) |=> (!scl_hold && flags[1:0] == 2'b00));

  assert_w1c_keeps_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (scl_hold && bus_wr && bus_addr == FLAG_OFS && !chk_rel) |=> scl_hold);

  assert_irq_follow_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|($past(flags) & $past(irq_en)))));

endmodule

bind i2c_hflag_ctrl i2c_hflag_ctrl_chk #(
  .LW(LW), .ERR_N(ERR_N), .AW(AW), .FLAG_OFS(FLAG_OFS), .ADDR_OFS(ADDR_OFS),
  .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS), .CMD_LSB(CMD_LSB), .CMD_W(CMD_W)
) u_chk (.*);

// File: tb/i2c_hflag_ctrl_test.sv
`timescale 1ns/1ps
module i2c_hflag_ctrl_test;

  localparam int DEPTH = 16;
  localparam int LW    = 5;
  localparam int ERR_N = 4;
  localparam int AW    = 8;
  localparam logic [7:0] A_FLAG = 8'h18, A_ADDR = 8'h24, A_DATA = 8'h28, A_CMD = 8'h04;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_arb_lost = 0, ev_nack_arb_lost = 0;
  logic ev_bus_err = 0, ev_start_unknown = 0;
  logic [ERR_N-1:0] err_src = '0;
  logic [LW-1:0] rx_level = '0, rx_thresh = 5'd4, tx_level = 5'd16, tx_thresh = 5'd6;
  logic bus_wr = 0, bus_rd = 0, smart_en = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, irq_en = '0;
  logic [7:0] flags;
  logic scl_hold, irq;

  always #4 clk = ~clk;

  i2c_hflag_ctrl uut (
    .clk(clk), .rst(rst), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
    .ev_arb_lost(ev_arb_lost), .ev_nack_arb_lost(ev_nack_arb_lost),
    .ev_bus_err(ev_bus_err), .ev_start_unknown(ev_start_unknown), .err_src(err_src),
    .rx_level(rx_level), .rx_thresh(rx_thresh), .tx_level(tx_level), .tx_thresh(tx_thresh),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .smart_en(smart_en), .irq_en(irq_en), .flags(flags), .scl_hold(scl_hold), .irq(irq)
  );

  typedef struct {
    logic [7:0] f;
    logic       h;
    logic       i;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  // Reference model state
  logic [7:0] m_f = 0;
  logic m_h = 0, m_i = 0, m_rxq = 0, m_txq = 0;

  task automatic tick(input string tag);
    exp_t e;
    logic rx_c, tx_c, rel, sb_s, mb_s, er_s, arb;
    logic [LW-1:0] freec;
    logic [7:0] w1c, setv, clrv;
    freec = LW'(DEPTH) - tx_level;
    rx_c  = (rx_level != 0) && (rx_level >= rx_thresh);
    tx_c  = (freec != 0) && (freec >= tx_thresh);
    rel   = (bus_wr && (bus_addr == A_ADDR || bus_addr == A_DATA))
          || (bus_rd && bus_addr == A_DATA && smart_en)
          || (bus_wr && bus_addr == A_CMD && bus_wdata[1:0] != 0);
    w1c   = (bus_wr && bus_addr == A_FLAG) ? bus_wdata : 8'h00;
    arb   = ev_arb_lost || ev_nack_arb_lost;
    sb_s  = ev_rx_done && !ev_arb_lost && !ev_bus_err;
    mb_s  = ev_tx_done || ev_nack_arb_lost || ev_start_unknown;
    er_s  = (|err_src) || arb || ev_bus_err;
    setv  = {er_s, 2'b00, rx_c && !m_rxq, tx_c && !m_txq, 1'b0, sb_s, mb_s};
    clrv  = w1c | {3'b000, rx_level == 0, freec == 0, 1'b0, rel, rel};
    if (rst) begin
      m_f = 0; m_h = 0; m_i = 0; m_rxq = 0; m_txq = 0;
    end else begin
      m_i   = |(m_f & irq_en);
      m_f   = (setv | (m_f & ~clrv)) & 8'h9B;
      m_h   = sb_s || (mb_s && !arb) || (m_h && !rel);
      m_rxq = rx_c;
      m_txq = tx_c;
    end
    e.f = m_f; e.h = m_h; e.i = m_i; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    ev_tx_done = 0; ev_rx_done = 0; ev_arb_lost = 0; ev_nack_arb_lost = 0;
    ev_bus_err = 0; ev_start_unknown = 0; err_src = '0;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick(tag);
  endtask

  // Monitor: pops one expectation after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (flags !== e.f || scl_hold !== e.h || irq !== e.i) begin
          n_fail++;
          $display("FAIL %s: flags=%h hold=%b irq=%b expected flags=%h hold=%b irq=%b",
                   e.tag, flags, scl_hold, irq, e.f, e.h, e.i);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    tick("R1 reset");
    rst = 0;
    tick("R1 idle");
    tick("R5 tx start full");

    // R3: each error source on its own
    for (int k = 0; k < ERR_N; k++) begin
      err_src = ERR_N'(1) << k;
      tick("R3 err_src");
      wr(A_FLAG, 8'h80, "R2 clear error");
    end
    ev_arb_lost = 1; tick("R3 arb lost");
    wr(A_FLAG, 8'h00, "R2 write zero no effect");
    wr(A_FLAG, 8'h7F, "R2 other bits no effect");
    wr(A_FLAG, 8'h80, "R2 w1c error");
    ev_bus_err = 1; tick("R3 bus error");

    // R11: interrupt masking
    irq_en = 8'h01; tick("R11 masked");
    irq_en = 8'h80; tick("R11 enable");
    tick("R11 irq high");
    wr(A_FLAG, 8'h80, "R11 clear");
    tick("R11 irq low");

    // R4: receive threshold
    rx_level = 5'd3; tick("R4 below");
    rx_level = 5'd4; tick("R4 reach");
    wr(A_FLAG, 8'h10, "R4 w1c");
    rx_level = 5'd5; tick("R4 no retrigger");
    rx_level = 5'd2; tick("R4 below again");
    rx_level = 5'd4; tick("R4 reach again");
    rx_level = 5'd0; tick("R4 empty clears");

    // R5: transmit free space
    tx_level = 5'd10; tick("R5 free reach");
    tick("R5 hold level");
    tx_level = 5'd16; tick("R5 full clears");

    // R6 and R8: client flag and release variants
    ev_rx_done = 1; tick("R6 rx byte");
    bus_rd = 1; bus_addr = A_DATA; tick("R8 read no smart");
    smart_en = 1; bus_rd = 1; bus_addr = A_DATA; tick("R8 smart read");
    smart_en = 0;
    ev_rx_done = 1; ev_arb_lost = 1; tick("R6 rx with arb lost");
    ev_rx_done = 1; ev_bus_err = 1; tick("R6 rx with bus err");
    ev_rx_done = 1; tick("R6 rx byte 2");
    wr(A_CMD, 8'h00, "R8 zero command");
    wr(A_CMD, 8'h02, "R8 valid command");
    ev_rx_done = 1; tick("R6 rx byte 3");
    wr(A_ADDR, 8'h55, "R8 addr write");
    wr(A_FLAG, 8'h80, "R2 clear error");

    // R7: host flag
    ev_tx_done = 1; ev_bus_err = 1; tick("R7 tx with bus err");
    wr(A_DATA, 8'hA5, "R8 data write");
    ev_tx_done = 1; ev_arb_lost = 1; tick("R7 tx with arb lost no hold");
    wr(A_FLAG, 8'h81, "R2 w1c two bits");
    ev_nack_arb_lost = 1; tick("R7 nack arb no hold");
    wr(A_FLAG, 8'h81, "R2 clear");
    ev_start_unknown = 1; tick("R7 start unknown");

    // R9: w1c leaves hold
    wr(A_FLAG, 8'h03, "R9 w1c keeps hold");
    tick("R9 still held");
    wr(A_ADDR, 8'h00, "R8 release after w1c");

    // R10: collisions
    err_src = 4'b0100; bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 8'h80;
    tick("R10 error set beats w1c");
    ev_tx_done = 1; bus_wr = 1; bus_addr = A_ADDR; bus_wdata = 8'h00;
    tick("R10 set beats release");
    ev_rx_done = 1; bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 8'h02;
    tick("R10 sb set beats w1c");
    rx_level = 5'd4; bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 8'h10;
    tick("R10 rxff set beats w1c");
    irq_en = 8'h9B; tick("R11 all enabled");
    tick("R11 irq on");

    rst = 1; tick("R1 reset again");
    rst = 0; tick("R1 after reset");

    @(posedge clk);
    #3;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule